// File: doc/BRIEF.md
# Host Power-Management Mailbox Channel

This block is a byte-wide mailbox between a host I/O bus and a local controller core. The host sees two I/O ports: a command port, which returns the status byte when read, and a data port. Any host write to either port loads the input buffer, sets input-full and records whether the byte arrived through the command port or the data port. The core takes the byte through a small register bus. A core read of the data-in register empties the input buffer.

In the other direction, the core writes a result byte to the data-out register. That sets output-full until the host reads the data port. The core also owns three status flags that the host sees in its status byte: busy, SCI pending and SMI pending. Two level interrupts, each gated by an enable bit, tell the core that a byte has arrived or that the host has drained the output buffer. A sticky overrun flag records a host write that replaced a byte the core had not yet read.

Top module: `host_pm_mailbox`

## Requirements
- R1: After reset, the host status byte is 0x00. The core control register reads 0x00. Both interrupts are low, and a host read of the data port returns 0x00.
- R2: A host write to the command port (default 0x200) or to the data port (default 0x204) stores the byte and sets input-full (status bit 1). Status bit 3 becomes 1 for a command-port write and 0 for a data-port write.
- R3: A core read of core register 0 (data-in) returns the stored byte and clears input-full on the next edge. If a host write lands in the same cycle, input-full stays set, the new byte is kept and no overrun is recorded.
- R4: A core write of core register 1 (data-out) sets output-full (status bit 0). A host read of the data port returns that byte and clears output-full. If a core write lands in the same cycle as the host read, output-full stays set with the new byte.
- R5: A core write of core register 2 copies written bit 2 to busy, bit 4 to SCI pending and bit 5 to SMI pending. These appear at the same positions in the host status byte. The other written bits have no effect. A core read of register 2 returns the status byte.
- R6: A host read of the status byte changes no flag.
- R7: A host write while input-full is set replaces the byte and sets a sticky overrun flag (core register 3, bit 7). The flag stays set until the core writes register 3 with bit 7 high. A host write to an empty buffer does not set it.
- R8: irq_ibf_o is high exactly while input-full is set and enable bit 0 of core register 3 is 1. irq_obe_o is high exactly while output-full is clear and enable bit 1 of core register 3 is 1.
- R9: Host accesses to any address other than the two ports change no state and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 16 | Host I/O address |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte (status or data-out) |
| core_addr_i | input | 2 | Core register select |
| core_wr_i | input | 1 | Core write strobe |
| core_rd_i | input | 1 | Core read strobe |
| core_wdata_i | input | 8 | Core write byte |
| core_rdata_o | output | 8 | Core read byte |
| irq_ibf_o | output | 1 | Input-full interrupt level |
| irq_obe_o | output | 1 | Output-empty interrupt level |

## Verification
A flag left in the wrong state shows up in the host status byte on the first status read that follows. It also shows up on the interrupt pins in the same cycle, because both pins are driven combinationally from the flag registers. A wrong priority between set and clear in the same cycle only appears when the set and the clear are deliberately made to coincide. The bench therefore forces both such collisions: a host write against a core data-in read, and a core data-out write against a host data read. It then reads the flags and the overrun bit back on the next access. A lost or stale byte is exposed by the next read of the matching data register.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_SCI  = 4;
  localparam int ST_SMI  = 5;

  localparam int NUM_OWN = 3;
  localparam int OWN_POS [NUM_OWN] = '{ST_BUSY, ST_SCI, ST_SMI};

  localparam int CTL_IBF_IE = 0;
  localparam int CTL_OBE_IE = 1;
  localparam int CTL_OVR    = 7;

  typedef enum logic [1:0] {
    CR_DIN  = 2'd0,
    CR_DOUT = 2'd1,
    CR_STAT = 2'd2,
    CR_CTRL = 2'd3
  } core_reg_e;

  typedef struct packed {
    logic cmd_wr;
    logic data_wr;
    logic data_rd;
    logic stat_rd;
  } host_req_t;
endpackage

// File: rtl/hpm_host_dec.sv
module hpm_host_dec
  import hpm_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] CMD_PORT  = 'h200,
  parameter logic [AW-1:0] DATA_PORT = 'h204
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output host_req_t     req_o
);
  logic hit_cmd, hit_data;

  assign hit_cmd  = (addr_i == CMD_PORT);
  assign hit_data = (addr_i == DATA_PORT);

  always_comb begin
    req_o.cmd_wr  = wr_i & hit_cmd;
    req_o.data_wr = wr_i & hit_data;
    req_o.stat_rd = rd_i & hit_cmd;
    req_o.data_rd = rd_i & hit_data;
  end
endmodule

// File: rtl/hpm_in_buf.sv
module hpm_in_buf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          din_rd_i,
  output logic          ibf_o,
  output logic          cmd_tag_o,
  output logic [DW-1:0] din_o,
  output logic          ovr_set_o
);
  logic host_wr;

  assign host_wr = cmd_wr_i | data_wr_i;
  // a write landing on a full buffer that the core is not draining this cycle
  assign ovr_set_o = host_wr & ibf_o & ~din_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_o     <= 1'b0;
      cmd_tag_o <= 1'b0;
      din_o     <= '0;
    end else if (host_wr) begin
      ibf_o     <= 1'b1;
      cmd_tag_o <= cmd_wr_i;
      din_o     <= wdata_i;
    end else if (din_rd_i) begin
      ibf_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/hpm_core_regs.sv
module hpm_core_regs
  import hpm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    core_addr_i,
  input  logic          core_wr_i,
  input  logic          core_rd_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          ibf_i,
  input  logic          cmd_tag_i,
  input  logic [DW-1:0] din_i,
  input  logic          ovr_set_i,
  input  logic          host_data_rd_i,
  output logic          din_rd_o,
  output logic          dout_wr_o,
  output logic          obf_o,
  output logic          ovr_o,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] core_rdata_o,
  output logic          irq_ibf_o,
  output logic          irq_obe_o
);
  core_reg_e         sel;
  logic              stat_wr, ctrl_wr;
  logic [NUM_OWN-1:0] own_q;
  logic              ibf_ie_q, obe_ie_q;
  logic [DW-1:0]     ctrl_rd;

  assign sel       = core_reg_e'(core_addr_i);
  assign din_rd_o  = core_rd_i & (sel == CR_DIN);
  assign dout_wr_o = core_wr_i & (sel == CR_DOUT);
  assign stat_wr   = core_wr_i & (sel == CR_STAT);
  assign ctrl_wr   = core_wr_i & (sel == CR_CTRL);

  // output buffer; a core write beats a same-cycle host drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_o  <= 1'b0;
      dout_o <= '0;
    end else if (dout_wr_o) begin
      obf_o  <= 1'b1;
      dout_o <= core_wdata_i;
    end else if (host_data_rd_i) begin
      obf_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
    end else if (stat_wr) begin
      for (int k = 0; k < NUM_OWN; k++) own_q[k] <= core_wdata_i[OWN_POS[k]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_ie_q <= 1'b0;
      obe_ie_q <= 1'b0;
    end else if (ctrl_wr) begin
      ibf_ie_q <= core_wdata_i[CTL_IBF_IE];
      obe_ie_q <= core_wdata_i[CTL_OBE_IE];
    end
  end

  // sticky overrun; a new overrun wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ovr_o <= 1'b0;
    else if (ovr_set_i)                        ovr_o <= 1'b1;
    else if (ctrl_wr && core_wdata_i[CTL_OVR]) ovr_o <= 1'b0;
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_OBF] = obf_o;
    status_o[ST_IBF] = ibf_i;
    status_o[ST_CMD] = cmd_tag_i;
    for (int k = 0; k < NUM_OWN; k++) status_o[OWN_POS[k]] = own_q[k];
  end

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CTL_IBF_IE] = ibf_ie_q;
    ctrl_rd[CTL_OBE_IE] = obe_ie_q;
    ctrl_rd[CTL_OVR]    = ovr_o;
  end

  always_comb begin
    unique case (sel)
      CR_DIN:  core_rdata_o = din_i;
      CR_DOUT: core_rdata_o = '0;
      CR_STAT: core_rdata_o = status_o;
      default: core_rdata_o = ctrl_rd;
    endcase
  end

  assign irq_ibf_o = ibf_i & ibf_ie_q;
  assign irq_obe_o = ~obf_o & obe_ie_q;
endmodule

// File: rtl/host_pm_mailbox.sv
module host_pm_mailbox
  import hpm_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            AW        = 16,
  parameter logic [AW-1:0] CMD_PORT  = 'h200,
  parameter logic [AW-1:0] DATA_PORT = 'h204
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [1:0]    core_addr_i,
  input  logic          core_wr_i,
  input  logic          core_rd_i,
  input  logic [DW-1:0] core_wdata_i,
  output logic [DW-1:0] core_rdata_o,
  output logic          irq_ibf_o,
  output logic          irq_obe_o
);
  host_req_t     req;
  logic          ibf, obf, cmd_tag, ovr_set, ovr_flag, din_rd, dout_wr;
  logic [DW-1:0] din, dout, status;

  hpm_host_dec #(
    .AW(AW), .CMD_PORT(CMD_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .addr_i (host_addr_i),
    .wr_i   (host_wr_i),
    .rd_i   (host_rd_i),
    .req_o  (req)
  );

  hpm_in_buf #(.DW(DW)) u_in_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (req.cmd_wr),
    .data_wr_i (req.data_wr),
    .wdata_i   (host_wdata_i),
    .din_rd_i  (din_rd),
    .ibf_o     (ibf),
    .cmd_tag_o (cmd_tag),
    .din_o     (din),
    .ovr_set_o (ovr_set)
  );

  hpm_core_regs #(.DW(DW)) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .core_addr_i    (core_addr_i),
    .core_wr_i      (core_wr_i),
    .core_rd_i      (core_rd_i),
    .core_wdata_i   (core_wdata_i),
    .ibf_i          (ibf),
    .cmd_tag_i      (cmd_tag),
    .din_i          (din),
    .ovr_set_i      (ovr_set),
    .host_data_rd_i (req.data_rd),
    .din_rd_o       (din_rd),
    .dout_wr_o      (dout_wr),
    .obf_o          (obf),
    .ovr_o          (ovr_flag),
    .dout_o         (dout),
    .status_o       (status),
    .core_rdata_o   (core_rdata_o),
    .irq_ibf_o      (irq_ibf_o),
    .irq_obe_o      (irq_obe_o)
  );

  always_comb begin
    if (req.stat_rd)      host_rdata_o = status;
    else if (req.data_rd) host_rdata_o = dout;
    else                  host_rdata_o = '0;
  end
endmodule

// File: rtl/host_pm_mailbox_chk.sv
module host_pm_mailbox_chk
  import hpm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input host_req_t     req_i,
  input logic [1:0]    core_addr_i,
  input logic          core_wr_i,
  input logic [DW-1:0] core_wdata_i,
  input logic          din_rd_i,
  input logic          dout_wr_i,
  input logic          ibf_i,
  input logic          obf_i,
  input logic          cmd_tag_i,
  input logic          ovr_i,
  input logic [DW-1:0] status_i,
  input logic          irq_ibf_i,
  input logic          irq_obe_i
);
  logic host_wr, ovr_clr, quiet;
  assign host_wr = req_i.cmd_wr | req_i.data_wr;
  assign ovr_clr = core_wr_i && (core_addr_i == 2'd3) && core_wdata_i[CTL_OVR];
  assign quiet   = !host_wr && !din_rd_i && !dout_wr_i && !core_wr_i && !req_i.data_rd;

  a_r2_wr_sets_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr |=> ibf_i);
  a_r2_cmd_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i.cmd_wr |=> cmd_tag_i);
  a_r2_data_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i.data_wr |=> !cmd_tag_i);
  a_r3_rd_clears_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_rd_i && !host_wr) |=> !ibf_i);
  a_r4_wr_sets_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_wr_i |=> obf_i);
  a_r4_hrd_clears_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.data_rd && !dout_wr_i) |=> !obf_i);
  a_r6_stat_rd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.stat_rd && quiet) |=> $stable(status_i));
  a_r7_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr && ibf_i && !din_rd_i) |=> ovr_i);
  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !ovr_clr) |=> ovr_i);
  a_r8_irq_ibf_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ibf_i |-> status_i[ST_IBF]);
  a_r8_irq_obe_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_obe_i |-> !status_i[ST_OBF]);
endmodule

bind host_pm_mailbox host_pm_mailbox_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req),
  .core_addr_i  (core_addr_i),
  .core_wr_i    (core_wr_i),
  .core_wdata_i (core_wdata_i),
  .din_rd_i     (din_rd),
  .dout_wr_i    (dout_wr),
  .ibf_i        (ibf),
  .obf_i        (obf),
  .cmd_tag_i    (cmd_tag),
  .ovr_i        (ovr_flag),
  .status_i     (status),
  .irq_ibf_i    (irq_ibf_o),
  .irq_obe_i    (irq_obe_o)
);

// File: tb/host_pm_mailbox_tb.sv
`timescale 1ns/1ps
module host_pm_mailbox_tb;
  localparam logic [15:0] PC = 16'h200;
  localparam logic [15:0] PD = 16'h204;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic [1:0]  core_addr = '0;
  logic        core_wr = 1'b0, core_rd = 1'b0;
  logic [7:0]  core_wdata = '0, core_rdata;
  logic        irq_ibf, irq_obe;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  host_pm_mailbox u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_addr_i(host_addr), .host_wr_i(host_wr), .host_rd_i(host_rd),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .core_addr_i(core_addr), .core_wr_i(core_wr), .core_rd_i(core_rd),
    .core_wdata_i(core_wdata), .core_rdata_o(core_rdata),
    .irq_ibf_o(irq_ibf), .irq_obe_o(irq_obe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // monitor: pops expected read data as each read strobe is seen
  always @(negedge clk_i) begin
    if (rst_ni && (host_rd || core_rd)) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard-empty", 8'h00, 8'hFF);
      end else begin
        chk(tag_q.pop_front(), host_rd ? host_rdata : core_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic h_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk_i); #1;
    host_wr = 1'b0;
  endtask

  task automatic h_rd(input logic [15:0] a, input logic [7:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk_i); #1;
    host_addr = a; host_rd = 1'b1;
    @(posedge clk_i); #1;
    host_rd = 1'b0;
  endtask

  task automatic c_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    core_addr = a; core_wdata = d; core_wr = 1'b1;
    @(posedge clk_i); #1;
    core_wr = 1'b0;
  endtask

  task automatic c_rd(input logic [1:0] a, input logic [7:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk_i); #1;
    core_addr = a; core_rd = 1'b1;
    @(posedge clk_i); #1;
    core_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    c_rd(2'd2, 8'h00, "R1 core status");
    c_rd(2'd3, 8'h00, "R1 ctrl");
    h_rd(PC, 8'h00, "R1 host status");
    h_rd(PD, 8'h00, "R1 host data");
    chk("R1 irq_ibf", {7'd0, irq_ibf}, 8'h00);
    chk("R1 irq_obe", {7'd0, irq_obe}, 8'h00);

    // R2 / R3 data and command writes
    h_wr(PD, 8'h5A);
    h_rd(PC, 8'h02, "R2 data write status");
    c_rd(2'd0, 8'h5A, "R3 din");
    h_rd(PC, 8'h00, "R3 ibf cleared");
    h_wr(PC, 8'h81);
    h_rd(PC, 8'h0A, "R2 cmd write status");
    c_rd(2'd0, 8'h81, "R2 cmd byte");
    h_rd(PC, 8'h08, "R3 ibf cleared tag kept");

    // R4 output path
    c_wr(2'd1, 8'h3C);
    h_rd(PC, 8'h09, "R4 obf set");
    h_rd(PD, 8'h3C, "R4 host data");
    h_rd(PC, 8'h08, "R4 obf cleared");

    // R5 core-owned flags
    c_wr(2'd2, 8'hFF);
    h_rd(PC, 8'h3C, "R5 all own flags");
    c_rd(2'd2, 8'h3C, "R5 core status");
    c_wr(2'd2, 8'h14);
    h_rd(PC, 8'h1C, "R5 busy+sci");
    c_wr(2'd2, 8'h00);
    h_rd(PC, 8'h08, "R5 cleared");

    // R6 status read has no side effect
    h_wr(PD, 8'h11);
    h_rd(PC, 8'h02, "R6 status first");
    h_rd(PC, 8'h02, "R6 status second");
    c_rd(2'd0, 8'h11, "R6 byte intact");

    // R7 overrun
    h_wr(PD, 8'h22);
    h_wr(PD, 8'h33);
    c_rd(2'd3, 8'h80, "R7 overrun set");
    c_rd(2'd0, 8'h33, "R7 byte replaced");
    c_rd(2'd3, 8'h80, "R7 overrun sticky");
    c_wr(2'd3, 8'h80);
    c_rd(2'd3, 8'h00, "R7 overrun cleared");
    h_wr(PD, 8'h44);
    c_rd(2'd3, 8'h00, "R7 no overrun on empty");
    c_rd(2'd0, 8'h44, "R7 din");

    // R3 host write against core read in the same cycle
    h_wr(PD, 8'h55);
    fork
      c_rd(2'd0, 8'h55, "R3 concurrent din");
      h_wr(PD, 8'h66);
    join
    h_rd(PC, 8'h02, "R3 ibf kept on collision");
    c_rd(2'd3, 8'h00, "R3 no overrun on collision");
    c_rd(2'd0, 8'h66, "R3 new byte kept");

    // R8 interrupts
    c_wr(2'd3, 8'h03);
    chk("R8 obe irq enabled", {7'd0, irq_obe}, 8'h01);
    chk("R8 ibf irq idle", {7'd0, irq_ibf}, 8'h00);
    h_wr(PD, 8'h77);
    chk("R8 ibf irq on", {7'd0, irq_ibf}, 8'h01);
    c_rd(2'd0, 8'h77, "R8 din");
    chk("R8 ibf irq off", {7'd0, irq_ibf}, 8'h00);
    c_wr(2'd1, 8'h99);
    chk("R8 obe irq off", {7'd0, irq_obe}, 8'h00);
    h_rd(PD, 8'h99, "R8 host data");
    chk("R8 obe irq on", {7'd0, irq_obe}, 8'h01);
    c_wr(2'd3, 8'h00);
    chk("R8 obe irq disabled", {7'd0, irq_obe}, 8'h00);

    // R4 core write against host read in the same cycle
    c_wr(2'd1, 8'hA1);
    fork
      h_rd(PD, 8'hA1, "R4 concurrent host data");
      c_wr(2'd1, 8'hB2);
    join
    h_rd(PC, 8'h01, "R4 obf kept on collision");
    h_rd(PD, 8'hB2, "R4 new byte");
    h_rd(PC, 8'h00, "R4 obf cleared");

    // R9 other addresses ignored
    h_wr(16'h208, 8'hEE);
    h_wr(16'h201, 8'hEF);
    h_rd(PC, 8'h00, "R9 status unchanged");
    h_rd(16'h300, 8'h00, "R9 unmapped read");
    c_rd(2'd0, 8'h77, "R9 din unchanged");

    repeat (3) @(posedge clk_i);
    if (exp_q.size() != 0) chk("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule